// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the start and repeated-start conditions for an I2C bus master. Software sets a start-trigger bit with a one-cycle write strobe. The block keeps that request in a flag. It then drives the SDA and SCL low-enables of the open-drain pads in the order the bus protocol requires: SDA falls first while SCL is still high, and SCL follows only after a programmable hold time. A one-cycle done pulse marks the moment SCL has been pulled low.

The request is not lost when the bus cannot be used straight away. If another master owns the bus, the flag waits as a reservation and the start is issued on its own once the bus-busy input drops. If this master is stalled in a wait state, the request turns into a repeated start as soon as the wait ends. For a repeated start, SDA is released while SCL is low, then SCL is released for a setup time, and only then does SDA fall. Loss of arbitration, a release-bus command or dropping the interface enable cancels a pending or running request. Stop generation, data shifting and arbitration detection live outside this block. Only their results reach it as inputs.

Top module: `i2c_start_gen`

## Requirements
- R1: A start write (`start_wr`=1) sets `start_flag` at the next clock edge, but only when `enable`=1 and `stop_wr`=0 in the same cycle.
- R2: On a free bus (`bus_busy`=0, `master_wait`=0) the cycle after `start_flag` is seen, `sda_low` rises while `scl_low` stays 0. This state lasts exactly HOLD_CYC cycles.
- R3: After the hold time, `scl_low`, `sda_low` and `start_done` are all 1 for exactly one cycle. `start_done` is never 1 at any other time.
- R4: `start_flag` is cleared the cycle after `start_done`, and both line enables return to 0.
- R5: While `bus_busy`=1 and `master_wait`=0, a set `start_flag` causes no line activity. Once `bus_busy` returns to 0, the free-bus sequence of R2 and R3 follows.
- R6: Bus-busy is sampled on every clock until SDA is pulled low. If the bus turns busy after the flag was set but before `sda_low` rises, the request stays pending and `sda_low` stays 0.
- R7: With `master_wait`=1, a set flag waits with both enables at 0. After `master_wait` falls, the block drives `scl_low`=1 with `sda_low`=0 for SETUP_CYC cycles. It then drives both at 0 for SETUP_CYC cycles, then the hold phase of R2, then R3.
- R8: A write with `start_wr`=1 and `stop_wr`=1 in the same cycle is ignored: `start_flag` stays 0 and no line is driven.
- R9: While `enable`=0, a start write has no effect, and `start_flag` is held at 0.
- R10: A pulse on `arb_lost` or `release_bus` clears `start_flag` at the next edge. From that edge on, both line enables are 0, including when it arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable; 0 blocks and clears the trigger |
| start_wr | input | 1 | One-cycle write strobe setting the start trigger |
| stop_wr | input | 1 | Stop-trigger write strobe, used only to reject a simultaneous start write |
| bus_busy | input | 1 | Bus held by a master, synchronous |
| master_wait | input | 1 | This master is in its wait state |
| arb_lost | input | 1 | Arbitration-lost pulse |
| release_bus | input | 1 | Release-bus command pulse |
| start_flag | output | 1 | Start trigger / reservation flag |
| sda_low | output | 1 | Drive SDA pad low |
| scl_low | output | 1 | Drive SCL pad low |
| start_done | output | 1 | One-cycle pulse when SCL has been pulled low after a start |

## Verification
The main sequence is tried with four patterns. The first is a request on an idle bus. The second is a request made while the bus is busy and freed later, which shows that a reservation is kept and released. The third is a bus that turns busy between the flag being set and SDA falling, which shows that free-bus sampling happens every cycle. The fourth is a request made during a master wait, which must give the three-phase repeated start instead of the plain one. The phase lengths are measured cycle by cycle, so a swapped or shortened hold or setup time shows up. Cancelling patterns (simultaneous stop write, disabled interface, arbitration loss while reserved, release-bus during the hold phase) check that the flag and both lines are left clear.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PEND   = 3'd1,
        ST_RS_SDA = 3'd2,
        ST_RS_SCL = 3'd3,
        ST_HOLD   = 3'd4,
        ST_DONE   = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/i2cs_trig_flag.sv
module i2cs_trig_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_wr,
    input  logic stop_wr,
    input  logic cancel,
    input  logic issued,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (enable && start_wr && !stop_wr)
            flag_d = 1'b1;
        if (!enable || cancel || issued)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/i2cs_timer.sv
module i2cs_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2cs_pkg::*;
#(
    parameter int HOLD_CYC  = 5,
    parameter int SETUP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_wr,
    input  logic stop_wr,
    input  logic bus_busy,
    input  logic master_wait,
    input  logic arb_lost,
    input  logic release_bus,
    output logic start_flag,
    output logic sda_low,
    output logic scl_low,
    output logic start_done
);
    localparam int MAXC = (HOLD_CYC > SETUP_CYC) ? HOLD_CYC : SETUP_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);

    seq_regs_t     r_d, r_q;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_exp;
    logic          abort;
    logic          issued;

    assign abort  = !enable || arb_lost || release_bus;
    assign issued = (r_q.state == ST_DONE);

    i2cs_trig_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start_wr (start_wr),
        .stop_wr  (stop_wr),
        .cancel   (arb_lost || release_bus),
        .issued   (issued),
        .flag     (start_flag)
    );

    i2cs_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_flag) begin
                    if (master_wait) begin
                        r_d.state = ST_PEND;
                    end else if (!bus_busy) begin
                        r_d.state = ST_HOLD;
                        t_load    = 1'b1;
                        t_val     = HOLD_LD;
                    end
                end
            end
            ST_PEND: begin
                if (!master_wait) begin
                    r_d.state = ST_RS_SDA;
                    t_load    = 1'b1;
                    t_val     = SETUP_LD;
                end
            end
            ST_RS_SDA: begin
                if (t_exp) begin
                    r_d.state = ST_RS_SCL;
                    t_load    = 1'b1;
                    t_val     = SETUP_LD;
                end
            end
            ST_RS_SCL: begin
                if (t_exp) begin
                    r_d.state = ST_HOLD;
                    t_load    = 1'b1;
                    t_val     = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (t_exp) r_d.state = ST_DONE;
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
        if (abort) r_d.state = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign sda_low    = (r_q.state == ST_HOLD) || (r_q.state == ST_DONE);
    assign scl_low    = (r_q.state == ST_RS_SDA) || (r_q.state == ST_DONE);
    assign start_done = issued;
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic start_wr,
    input logic stop_wr,
    input logic arb_lost,
    input logic release_bus,
    input logic start_flag,
    input logic sda_low,
    input logic scl_low,
    input logic start_done
);
    // R2
    sda_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> !scl_low);

    // R3
    done_after_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |-> $past(sda_low) && !$past(scl_low));

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> !start_flag && !start_done);

    // R8
    both_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && stop_wr && !start_flag) |=> !start_flag);

    // R9
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !start_flag);

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost || release_bus) |=> !start_flag && !sda_low && !scl_low);
endmodule

bind i2c_start_gen i2c_start_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .start_wr    (start_wr),
    .stop_wr     (stop_wr),
    .arb_lost    (arb_lost),
    .release_bus (release_bus),
    .start_flag  (start_flag),
    .sda_low     (sda_low),
    .scl_low     (scl_low),
    .start_done  (start_done)
);

// File: tb/i2c_start_gen_tb_top.sv
module i2c_start_gen_tb_top;
    localparam int HOLD  = 5;
    localparam int SETUP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, start_wr = 1'b0, stop_wr = 1'b0;
    logic bus_busy = 1'b0, master_wait = 1'b0;
    logic arb_lost = 1'b0, release_bus = 1'b0;
    logic start_flag, sda_low, scl_low, start_done;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    i2c_start_gen #(.HOLD_CYC(HOLD), .SETUP_CYC(SETUP)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .start_wr    (start_wr),
        .stop_wr     (stop_wr),
        .bus_busy    (bus_busy),
        .master_wait (master_wait),
        .arb_lost    (arb_lost),
        .release_bus (release_bus),
        .start_flag  (start_flag),
        .sda_low     (sda_low),
        .scl_low     (scl_low),
        .start_done  (start_done)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lines();
        return {29'd0, start_flag, sda_low, scl_low};
    endfunction

    task automatic pulse_start();
        start_wr = 1'b1;
        tick();
        start_wr = 1'b0;
    endtask

    // Called in the first cycle with sda_low=1: measures hold, then done and cleanup
    task automatic finish_start(input string tag);
        int n = 0;
        while (sda_low && !scl_low && n < 100) begin
            n++;
            tick();
        end
        chk(n == HOLD, {tag, " R2 hold length"}, n, HOLD);
        chk(sda_low && scl_low && start_done, {tag, " R3 done phase"},
            {start_done, sda_low, scl_low}, 7);
        tick();
        chk(!start_done && !start_flag && !sda_low && !scl_low,
            {tag, " R4 cleared"}, lines() + 8 * start_done, 0);
    endtask

    task automatic t_reset();
        chk(lines() == 0 && !start_done, "R4 reset state", lines(), 0);
    endtask

    task automatic t_free();
        pulse_start();
        chk(start_flag && !sda_low, "R1 flag set", lines(), 4);
        tick();
        chk(sda_low && !scl_low, "R2 sda first", lines(), 6);
        finish_start("free");
    endtask

    task automatic t_reserve();
        bus_busy = 1'b1;
        pulse_start();
        repeat (10) tick();
        chk(start_flag && !sda_low && !scl_low, "R5 reserved idle", lines(), 4);
        bus_busy = 1'b0;
        tick();
        chk(sda_low && !scl_low, "R5 issued when free", lines(), 6);
        finish_start("reserve");
    endtask

    task automatic t_busy_late();
        pulse_start();
        bus_busy = 1'b1;
        repeat (6) tick();
        chk(start_flag && !sda_low, "R6 stays pending", lines(), 4);
        bus_busy = 1'b0;
        tick();
        chk(sda_low && !scl_low, "R6 issued later", lines(), 6);
        finish_start("late");
    endtask

    task automatic t_restart();
        int n;
        master_wait = 1'b1;
        bus_busy    = 1'b1;
        pulse_start();
        repeat (5) tick();
        chk(start_flag && !sda_low && !scl_low, "R7 waiting", lines(), 4);
        master_wait = 1'b0;
        tick();
        n = 0;
        while (scl_low && !sda_low && n < 100) begin
            n++;
            tick();
        end
        chk(n == SETUP, "R7 scl low sda high phase", n, SETUP);
        n = 0;
        while (!scl_low && !sda_low && n < 100) begin
            n++;
            tick();
        end
        chk(n == SETUP, "R7 both high phase", n, SETUP);
        finish_start("R7 restart");
        bus_busy = 1'b0;
    endtask

    task automatic t_both();
        start_wr = 1'b1;
        stop_wr  = 1'b1;
        tick();
        start_wr = 1'b0;
        stop_wr  = 1'b0;
        repeat (4) tick();
        chk(lines() == 0, "R8 start+stop ignored", lines(), 0);
    endtask

    task automatic t_disabled();
        enable = 1'b0;
        pulse_start();
        repeat (4) tick();
        chk(lines() == 0, "R9 disabled ignored", lines(), 0);
        enable = 1'b1;
        tick();
    endtask

    task automatic t_arb();
        bus_busy = 1'b1;
        pulse_start();
        arb_lost = 1'b1;
        tick();
        arb_lost = 1'b0;
        chk(!start_flag, "R10 arb clears flag", lines(), 0);
        bus_busy = 1'b0;
        repeat (4) tick();
        chk(lines() == 0, "R10 no start after arb", lines(), 0);
    endtask

    task automatic t_release();
        pulse_start();
        tick();
        tick();
        chk(sda_low, "R10 in hold before release", lines(), 6);
        release_bus = 1'b1;
        tick();
        release_bus = 1'b0;
        chk(lines() == 0, "R10 release aborts", lines(), 0);
        repeat (3) tick();
        chk(lines() == 0 && !start_done, "R10 stays idle", lines(), 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n  = 1'b1;
        enable = 1'b1;
        tick();
        t_free();
        t_reserve();
        t_busy_late();
        t_restart();
        t_both();
        t_disabled();
        t_arb();
        t_release();
        t_free();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule